// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device from power-on to a usable state before the memory controller takes over the command bus. After reset it reads a memory-type selector once. It then walks a fixed, type-specific list of steps. Each step either raises the clock enable or issues one command on a single-phase bus: chip select, RAS, CAS and WE, all active low, plus row address and bank address. After each step it waits a set number of cycles. The mode-register words are computed in hardware from the CAS latency, the number of PHY phases (which sets the burst length) and, for DDR2, a write-recovery value.

The controller drives the selector and holds it steady through reset. It connects the command outputs to the PHY through a multiplexer and switches that multiplexer over to itself once `init_done` rises. An unsupported selector value runs no sequence. In that case the clock enable stays low and `init_err` rises.

FSM states: `ST_BOOT` samples the type, goes to `ST_ISSUE` for types 0 to 3 and to `ST_FAULT` otherwise. `ST_ISSUE` presents the current step for one cycle. From there it goes to `ST_WAIT` when the step has a non-zero wait, to `ST_ISSUE` of the next step when the wait is zero, and to `ST_DONE` when a zero-wait step is the last one. `ST_WAIT` counts down. When the count expires it goes to `ST_ISSUE` of the next step, or to `ST_DONE` after the last step. `ST_DONE` and `ST_FAULT` hold until reset.

Top module: `sdinit_seq`

## Requirements
- R1: While reset is held, `cke` is 0, the bus is NOP (`cs_n`, `ras_n`, `cas_n` and `we_n` all 1), and `init_done` and `init_err` are 0.
- R2: `mem_type` is sampled only in the first cycle after reset: 0 = SDR, 1 = DDR, 2 = LPDDR, 3 = DDR2. Later changes to it have no effect. Values 4 to 7 raise `init_err` one cycle after sampling. In that case `cke` stays 0, no command is issued and `init_done` stays 0.
- R3: The first step raises `cke`. The first command comes exactly CKE_WAIT cycles (2000 by default) after the first cycle in which `cke` is high, and `cke` stays high afterwards.
- R4: The command codes, given as {cs_n,ras_n,cas_n,we_n}, are: precharge-all = 0010 with address 0x400 (A10 set) and bank 0; auto-refresh = 0001 with address 0 and bank 0; mode load = 0000; NOP = 1111.
- R5: Each step is presented for exactly one clock. The next step follows after wait+1 cycles, so steps with no wait are issued back to back.
- R6: The base mode word is log2(BL) + (CAS_LAT << 4). BL is NPHASES for SDR and 2*NPHASES for the other types. DDR2 adds (2 << 9). With the defaults (NPHASES=2, CAS_LAT=3) this gives SDR 0x031, DDR/LPDDR 0x032 and DDR2 0x432.
- R7: The first mode load on bank 0 uses the base word with bit 8 set (DLL reset) and waits MRS_WAIT (200) cycles.
- R8: Every type begins with the CKE step and then precharge-all. Every type contains the tail DLL-reset mode load, precharge-all, two auto-refreshes (REF_WAIT = 4 cycles each) and a base mode load on bank 0 with a MRS_WAIT wait. For SDR the tail follows the first precharge directly. SDR issues 6 commands, DDR and LPDDR 7, DDR2 11.
- R9: DDR loads the extended mode register with 0 on bank 1, and LPDDR with 0 on bank 2. This load sits between the first precharge and the DLL-reset load and has no wait.
- R10: After the first precharge, DDR2 issues zero-valued loads on banks 3, 2 and 1, in that order. After the tail it issues a load of 0x380 on bank 1 (OCD default) and then a load of 0 on bank 1 (OCD exit). None of these has a wait.
- R11: `init_done` rises wait+1 cycles after the last command, where wait is that command's own wait (200 for SDR/DDR/LPDDR, 0 for DDR2). It stays high, and no command follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_type | input | 3 | Memory type selector, sampled once after reset |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Row address / mode word |
| bank | output | BANK_W | Bank address |
| init_done | output | 1 | Sequence complete, sticky |
| init_err | output | 1 | Unsupported memory type, sticky |

## Verification
Every result in this block is a cycle distance. The gap between two command cycles must be the earlier step's wait plus one. The first command comes CKE_WAIT cycles after the first cycle with `cke` high. `init_done` comes one cycle after the final wait, and `init_err` one cycle after the type is sampled. The bench stamps each sampled cycle with a counter taken at the falling edge, records every command with its stamp, and compares stamp differences against the expected waits. It computes the expected list and the mode words for all four types, and for two unsupported selector values, from the arithmetic in the requirements. Because the checks compare differences, they do not depend on where counting starts.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

    // memory type selector codes
    localparam logic [1:0] MT_SDR   = 2'd0;
    localparam logic [1:0] MT_DDR   = 2'd1;
    localparam logic [1:0] MT_LPDDR = 2'd2;
    localparam logic [1:0] MT_DDR2  = 2'd3;

    localparam int STEP_IDX_W = 4;

    typedef enum logic [1:0] {K_CKE, K_PRE, K_REF, K_MRS} step_kind_t;
    typedef enum logic [2:0] {AD_ZERO, AD_PALL, AD_MODE, AD_MODE_DLL, AD_OCD} addr_sel_t;
    typedef enum logic [1:0] {WT_NONE, WT_CKE, WT_MRS, WT_REF} wait_sel_t;

    typedef struct packed {
        step_kind_t kind;
        addr_sel_t  asel;
        logic [1:0] bank;
        wait_sel_t  wsel;
        logic       last;
    } step_t;

    function automatic step_t mk_step(step_kind_t k, addr_sel_t a, logic [1:0] b,
                                      wait_sel_t w, logic l);
        step_t s;
        s.kind = k;
        s.asel = a;
        s.bank = b;
        s.wsel = w;
        s.last = l;
        return s;
    endfunction

endpackage

// File: rtl/sdinit_mode_word.sv
module sdinit_mode_word
    import sdinit_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int NPHASES  = 2,
    parameter int CAS_LAT  = 3,
    parameter int WR_RECOV = 2
) (
    input  logic [1:0]        mtype,
    output logic [ADDR_W-1:0] mode_base,
    output logic [ADDR_W-1:0] mode_dll
);
    localparam int PH_LOG2 = $clog2(NPHASES);
    localparam logic [ADDR_W-1:0] CL_FIELD  = ADDR_W'(CAS_LAT << 4);
    localparam logic [ADDR_W-1:0] WR_FIELD  = ADDR_W'(WR_RECOV << 9);
    localparam logic [ADDR_W-1:0] DLL_FIELD = ADDR_W'(1 << 8);

    logic [ADDR_W-1:0] bl_log2;

    always_comb begin
        // double data rate types carry twice the phases per burst
        bl_log2   = ADDR_W'(PH_LOG2) + ((mtype != MT_SDR) ? ADDR_W'(1) : ADDR_W'(0));
        mode_base = bl_log2 + CL_FIELD + ((mtype == MT_DDR2) ? WR_FIELD : '0);
        mode_dll  = mode_base | DLL_FIELD;
    end
endmodule

// File: rtl/sdinit_step_table.sv
module sdinit_step_table
    import sdinit_pkg::*;
(
    input  logic [1:0]            mtype,
    input  logic [STEP_IDX_W-1:0] idx,
    output step_t                 step
);
    logic [STEP_IDX_W-1:0] head_len;
    logic [STEP_IDX_W-1:0] tail_idx;
    logic [1:0]            emr_bank;

    always_comb begin
        unique case (mtype)
            MT_SDR:   head_len = STEP_IDX_W'(2);
            MT_DDR:   head_len = STEP_IDX_W'(3);
            MT_LPDDR: head_len = STEP_IDX_W'(3);
            default:  head_len = STEP_IDX_W'(5);
        endcase

        tail_idx = idx - head_len;

        // extended loads in the head: DDR bank 1, LPDDR bank 2, DDR2 banks 3,2,1
        unique case (mtype)
            MT_DDR:   emr_bank = 2'd1;
            MT_LPDDR: emr_bank = 2'd2;
            default:  emr_bank = 2'(5 - int'(idx));
        endcase

        if (idx == '0) begin
            step = mk_step(K_CKE, AD_ZERO, 2'd0, WT_CKE, 1'b0);
        end else if (idx == STEP_IDX_W'(1)) begin
            step = mk_step(K_PRE, AD_PALL, 2'd0, WT_NONE, 1'b0);
        end else if (idx < head_len) begin
            step = mk_step(K_MRS, AD_ZERO, emr_bank, WT_NONE, 1'b0);
        end else begin
            case (tail_idx)
                STEP_IDX_W'(0): step = mk_step(K_MRS, AD_MODE_DLL, 2'd0, WT_MRS, 1'b0);
                STEP_IDX_W'(1): step = mk_step(K_PRE, AD_PALL, 2'd0, WT_NONE, 1'b0);
                STEP_IDX_W'(2): step = mk_step(K_REF, AD_ZERO, 2'd0, WT_REF, 1'b0);
                STEP_IDX_W'(3): step = mk_step(K_REF, AD_ZERO, 2'd0, WT_REF, 1'b0);
                STEP_IDX_W'(4): step = mk_step(K_MRS, AD_MODE, 2'd0, WT_MRS, mtype != MT_DDR2);
                STEP_IDX_W'(5): step = mk_step(K_MRS, AD_OCD, 2'd1, WT_NONE, 1'b0);
                STEP_IDX_W'(6): step = mk_step(K_MRS, AD_ZERO, 2'd1, WT_NONE, 1'b1);
                default:        step = mk_step(K_PRE, AD_PALL, 2'd0, WT_NONE, 1'b1);
            endcase
        end
    end
endmodule

// File: rtl/sdinit_delay.sv
module sdinit_delay #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign expire = dec && (cnt == CNT_W'(1));
endmodule

// File: rtl/sdinit_seq.sv
module sdinit_seq
    import sdinit_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int BANK_W   = 2,
    parameter int NPHASES  = 2,
    parameter int CAS_LAT  = 3,
    parameter int WR_RECOV = 2,
    parameter int CKE_WAIT = 2000,
    parameter int MRS_WAIT = 200,
    parameter int REF_WAIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mem_type,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank,
    output logic              init_done,
    output logic              init_err
);
    localparam int MAX_A    = (CKE_WAIT > MRS_WAIT) ? CKE_WAIT : MRS_WAIT;
    localparam int MAX_WAIT = (MAX_A > REF_WAIT) ? MAX_A : REF_WAIT;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);
    localparam logic [ADDR_W-1:0] PALL_WORD = ADDR_W'(1 << 10);
    localparam logic [ADDR_W-1:0] OCD_WORD  = ADDR_W'(7 << 7);

    typedef enum logic [2:0] {ST_BOOT, ST_ISSUE, ST_WAIT, ST_DONE, ST_FAULT} state_t;

    state_t                state, nxt;
    logic [1:0]            type_q;
    logic [STEP_IDX_W-1:0] idx;
    step_t                 step;
    logic [ADDR_W-1:0]     mode_base, mode_dll;
    logic [CNT_W-1:0]      wait_val;
    logic                  load, adv, expire, cke_q;

    sdinit_step_table u_table (
        .mtype (type_q),
        .idx   (idx),
        .step  (step)
    );

    sdinit_mode_word #(
        .ADDR_W   (ADDR_W),
        .NPHASES  (NPHASES),
        .CAS_LAT  (CAS_LAT),
        .WR_RECOV (WR_RECOV)
    ) u_mode (
        .mtype     (type_q),
        .mode_base (mode_base),
        .mode_dll  (mode_dll)
    );

    sdinit_delay #(.CNT_W(CNT_W)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (wait_val),
        .dec      (state == ST_WAIT),
        .expire   (expire)
    );

    always_comb begin
        unique case (step.wsel)
            WT_CKE:  wait_val = CNT_W'(CKE_WAIT);
            WT_MRS:  wait_val = CNT_W'(MRS_WAIT);
            WT_REF:  wait_val = CNT_W'(REF_WAIT);
            default: wait_val = '0;
        endcase
    end

    // transitions
    always_comb begin
        nxt  = state;
        load = 1'b0;
        adv  = 1'b0;
        unique case (state)
            ST_BOOT:  nxt = mem_type[2] ? ST_FAULT : ST_ISSUE;
            ST_ISSUE: begin
                if (step.wsel != WT_NONE) begin
                    nxt  = ST_WAIT;
                    load = 1'b1;
                end else if (step.last) begin
                    nxt = ST_DONE;
                end else begin
                    adv = 1'b1;
                end
            end
            ST_WAIT: begin
                if (expire) begin
                    if (step.last) begin
                        nxt = ST_DONE;
                    end else begin
                        nxt = ST_ISSUE;
                        adv = 1'b1;
                    end
                end
            end
            ST_DONE:  nxt = ST_DONE;
            ST_FAULT: nxt = ST_FAULT;
            default:  nxt = ST_FAULT;
        endcase
    end

    // state register and sequence position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_BOOT;
            idx    <= '0;
            type_q <= MT_SDR;
            cke_q  <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_BOOT) type_q <= mem_type[1:0];
            if (adv) idx <= idx + STEP_IDX_W'(1);
            if (state == ST_ISSUE && step.kind == K_CKE) cke_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        cs_n  = 1'b1;
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        addr  = '0;
        bank  = '0;
        if (state == ST_ISSUE && step.kind != K_CKE) begin
            cs_n  = 1'b0;
            ras_n = 1'b0;
            cas_n = (step.kind == K_PRE);
            we_n  = (step.kind == K_REF);
            bank  = BANK_W'(step.bank);
            unique case (step.asel)
                AD_PALL:     addr = PALL_WORD;
                AD_MODE:     addr = mode_base;
                AD_MODE_DLL: addr = mode_dll;
                AD_OCD:      addr = OCD_WORD;
                default:     addr = '0;
            endcase
        end
    end

    assign cke       = cke_q;
    assign init_done = (state == ST_DONE);
    assign init_err  = (state == ST_FAULT);
endmodule

// File: rtl/sdinit_seq_chk.sv
module sdinit_seq_chk #(
    parameter int ADDR_W   = 13,
    parameter int BANK_W   = 2,
    parameter int CKE_WAIT = 2000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [BANK_W-1:0] bank,
    input logic              init_done,
    input logic              init_err
);
    localparam int CW = $clog2(CKE_WAIT + 1);
    logic [CW-1:0] cke_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) cke_cnt <= '0;
        else if (cke && cke_cnt != CW'(CKE_WAIT)) cke_cnt <= cke_cnt + CW'(1);
    end

    p_cke_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> cke_cnt == CW'(CKE_WAIT));

    p_cke_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);

    p_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |=> (cs_n || !$stable({ras_n, cas_n, we_n, addr, bank})));

    p_done_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    p_nop_after_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> cs_n);

    p_fault_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        init_err |-> (!cke && cs_n && !init_done));

    p_err_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        init_err |=> init_err);

    p_nop_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (ras_n && cas_n && we_n));
endmodule

bind sdinit_seq sdinit_seq_chk #(
    .ADDR_W   (ADDR_W),
    .BANK_W   (BANK_W),
    .CKE_WAIT (CKE_WAIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .addr      (addr),
    .bank      (bank),
    .init_done (init_done),
    .init_err  (init_err)
);

// File: tb/sdinit_seq_bench.sv
module sdinit_seq_bench;
    localparam int AW = 13;
    localparam int BW = 2;
    localparam int NPH = 2;
    localparam int CL = 3;
    localparam int CKEW = 2000;
    localparam int MRSW = 200;
    localparam int REFW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] mem_type = 3'd0;
    logic cke, cs_n, ras_n, cas_n, we_n, init_done, init_err;
    logic [AW-1:0] addr;
    logic [BW-1:0] bank;

    always #5 clk = ~clk;

    sdinit_seq #(
        .ADDR_W(AW), .BANK_W(BW), .NPHASES(NPH), .CAS_LAT(CL), .WR_RECOV(2),
        .CKE_WAIT(CKEW), .MRS_WAIT(MRSW), .REF_WAIT(REFW)
    ) u_sdinit_seq (
        .clk(clk), .rst_n(rst_n), .mem_type(mem_type), .cke(cke),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .bank(bank), .init_done(init_done), .init_err(init_err)
    );

    int checks = 0;
    int fails = 0;

    // expected list
    int ecmd[0:15], eaddr[0:15], ebank[0:15], ewait[0:15];
    string erq[0:15];
    int n_exp;

    // observed
    int ocmd[0:15], oaddr[0:15], obank[0:15], ocyc[0:15];
    int n_obs, cyc, cke_cyc, done_cyc, err_cyc, cmd_after_done;
    bit done_drop, cke_seen, mon_en;

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", rq, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (mon_en) begin
            cyc++;
            if (!cs_n) begin
                if (n_obs < 16) begin
                    ocmd[n_obs]  = int'({cs_n, ras_n, cas_n, we_n});
                    oaddr[n_obs] = int'(addr);
                    obank[n_obs] = int'(bank);
                    ocyc[n_obs]  = cyc;
                end
                n_obs++;
                if (done_cyc >= 0) cmd_after_done++;
            end
            if (cke) cke_seen = 1'b1;
            if (cke && cke_cyc < 0) cke_cyc = cyc;
            if (init_done && done_cyc < 0) done_cyc = cyc;
            if (!init_done && done_cyc >= 0) done_drop = 1'b1;
            if (init_err && err_cyc < 0) err_cyc = cyc;
        end
    end

    task automatic push(input int c, input int a, input int b, input int w, input string rq);
        ecmd[n_exp] = c; eaddr[n_exp] = a; ebank[n_exp] = b; ewait[n_exp] = w; erq[n_exp] = rq;
        n_exp++;
    endtask

    // R4 codes: PRE 0010, REF 0001, MRS 0000
    task automatic build(input int t);
        int bl, mr;
        bl = (t == 0) ? NPH : 2 * NPH;
        mr = $clog2(bl) + (CL << 4) + ((t == 3) ? (2 << 9) : 0);
        n_exp = 0;
        push(4'b0010, 'h400, 0, 0, "R4");
        if (t == 1) push(4'b0000, 0, 1, 0, "R9");
        if (t == 2) push(4'b0000, 0, 2, 0, "R9");
        if (t == 3) begin
            push(4'b0000, 0, 3, 0, "R10");
            push(4'b0000, 0, 2, 0, "R10");
            push(4'b0000, 0, 1, 0, "R10");
        end
        push(4'b0000, mr | 'h100, 0, MRSW, "R7");
        push(4'b0010, 'h400, 0, 0, "R8");
        push(4'b0001, 0, 0, REFW, "R4");
        push(4'b0001, 0, 0, REFW, "R8");
        push(4'b0000, mr, 0, MRSW, "R6");
        if (t == 3) begin
            push(4'b0000, 'h380, 1, 0, "R10");
            push(4'b0000, 0, 1, 0, "R10");
        end
    endtask

    task automatic run(input int t, input bit switch_type);
        rst_n = 1'b0;
        mon_en = 1'b0;
        mem_type = 3'(t);
        repeat (3) @(negedge clk);
        chk(!cke && cs_n && ras_n && cas_n && we_n && !init_done && !init_err, "R1",
            "reset outputs", int'({cke, cs_n, ras_n, cas_n, we_n, init_done, init_err}),
            'b0111100);
        n_obs = 0; cyc = 0; cke_cyc = -1; done_cyc = -1; err_cyc = -1;
        cmd_after_done = 0; done_drop = 1'b0; cke_seen = 1'b0;
        rst_n = 1'b1;
        @(posedge clk);
        mon_en = 1'b1;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (switch_type && i == 10) mem_type = 3'd7;
            if (done_cyc >= 0 || (t > 3 && i > 3000)) break;
        end
        repeat (30) @(negedge clk);
        mon_en = 1'b0;

        if (t > 3) begin
            chk(err_cyc == 1, "R2", "err cycle", err_cyc, 1);
            chk(!cke_seen && n_obs == 0 && done_cyc < 0, "R2", "quiet after fault",
                n_obs, 0);
            return;
        end
        build(t);
        chk(err_cyc < 0, "R2", "no error", err_cyc, -1);
        chk(n_obs == n_exp, "R8", "command count", n_obs, n_exp);
        if (n_obs != n_exp) return;
        for (int i = 0; i < n_exp; i++)
            chk(ocmd[i] == ecmd[i] && oaddr[i] == eaddr[i] && obank[i] == ebank[i], erq[i],
                $sformatf("type %0d step %0d cmd/bank/addr", t, i),
                (ocmd[i] << 20) | (obank[i] << 16) | oaddr[i],
                (ecmd[i] << 20) | (ebank[i] << 16) | eaddr[i]);
        for (int i = 0; i + 1 < n_exp; i++)
            chk(ocyc[i+1] - ocyc[i] == ewait[i] + 1, "R5",
                $sformatf("type %0d gap after step %0d", t, i),
                ocyc[i+1] - ocyc[i], ewait[i] + 1);
        chk(ocyc[0] - cke_cyc == CKEW, "R3", "cke to first command", ocyc[0] - cke_cyc, CKEW);
        chk(done_cyc - ocyc[n_exp-1] == ewait[n_exp-1] + 1, "R11", "done latency",
            done_cyc - ocyc[n_exp-1], ewait[n_exp-1] + 1);
        chk(!done_drop && cmd_after_done == 0 && cke, "R11", "done sticky, bus quiet",
            cmd_after_done, 0);
    endtask

    initial begin
        for (int cnt = 0; cnt < 200000; cnt++) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        run(0, 1'b0);
        run(1, 1'b1);   // R2: selector changed mid-sequence must not matter
        run(2, 1'b0);
        run(3, 1'b0);
        run(4, 1'b0);
        run(7, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule